// File: doc/BRIEF.md
# Sequence-Numbering Stream Link Adapter

This block joins a host-facing pair of AXI4-Stream channels to a pair facing a serial link. In the outgoing direction it adds one trailing word to every frame, the sequence number. That number is either a local 32-bit count or, in echo mode, the number carried by the most recent incoming frame. In the incoming direction it can remove the trailing sequence word. It holds one word back in a skid register so that the word before the sequence number can carry TLAST. Software can turn all sequence handling off, and the block then passes frames through untouched in both directions.

A small register port exposes the link flags, a mode word and two 64-bit frame counters, each read as two 32-bit halves. A loopback mode turns the outgoing link stream back into the incoming path inside the block. The transceiver, lane bring-up and error detection sit outside the block; their flags arrive as plain inputs.

The outgoing path runs a four-state machine. TX_IDLE waits for the first word of a frame. From there it moves to TX_PASS when the first word is not last and handling is off. It moves to TX_BODY when the first word is not last and handling is on. It moves to TX_SEQ when the first word is last and handling is on. TX_PASS returns to TX_IDLE on the last word. TX_BODY moves to TX_SEQ on the last word. TX_SEQ returns to TX_IDLE once the sequence word is accepted.

The incoming path runs a three-state machine. RX_IDLE waits for the first word. It moves to RX_HOLD when stripping is active and the word is not last. It moves to RX_PASS when stripping is inactive and the word is not last. On a last word it stays in RX_IDLE. RX_PASS and RX_HOLD both return to RX_IDLE on the last input word.

Top module: `seqlink_wrap`

## Requirements
- R1: A read at address 0x00 returns the link flags with no register delay: bit 0 channel-up, bit 1 lane-up, bit 2 hard error, bit 3 soft error, bit 4 frame error, all other bits 0. A write to 0x00 changes nothing.
- R2: The mode word sits at address 0x04 and reads back its 5 written bits. Bit 0 is loopback, bit 1 is counter clear, bit 2 turns sequence handling off, bit 3 is strip and bit 4 is echo. The mode word is 0 after reset.
- R3: While mode bit 2 is 1, every frame passes through unchanged in both directions, and bits 3 and 4 have no effect. Frames that pass this way neither advance the local count nor update the remembered incoming number. The mode is fixed at the first word of each frame.
- R4: While handling is on, each outgoing frame leaves with TLAST cleared on all of its host words. One extra word carrying TLAST follows them.
- R5: With echo off, the extra word is the local count. That count is 0 after reset and rises by 1, wrapping at 2^32, after every frame that receives an extra word.
- R6: With echo on, the extra word equals the last word of the most recent incoming frame that was received with handling on.
- R7: With strip on and handling on, the last word of each incoming frame is removed, and the word before it is delivered with TLAST. With strip off, incoming frames are delivered unchanged.
- R8: A one-word incoming frame received with stripping active is dropped completely, and it still counts as an incoming frame.
- R9: The incoming frame counter reads at 0x08 (low half) and 0x0C (high half). The outgoing counter reads at 0x1C (low half) and 0x18 (high half). Each counter rises by 1 per TLAST handshake on the link side of the block.
- R10: While mode bit 1 is 1, both frame counters are held at 0. Counting resumes once the bit is cleared.
- R11: In loopback, the outgoing stream feeds the incoming path. The external link-side input sees TREADY low, and the external link-side output shows TVALID low.
- R12: Under backpressure on any interface, no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_tx_tdata | input | 32 | Host outgoing stream data |
| h_tx_tvalid | input | 1 | Host outgoing stream valid |
| h_tx_tlast | input | 1 | Host outgoing end of frame |
| h_tx_tready | output | 1 | Host outgoing stream ready |
| l_tx_tdata | output | 32 | Link outgoing stream data |
| l_tx_tvalid | output | 1 | Link outgoing stream valid |
| l_tx_tlast | output | 1 | Link outgoing end of frame |
| l_tx_tready | input | 1 | Link outgoing stream ready |
| l_rx_tdata | input | 32 | Link incoming stream data |
| l_rx_tvalid | input | 1 | Link incoming stream valid |
| l_rx_tlast | input | 1 | Link incoming end of frame |
| l_rx_tready | output | 1 | Link incoming stream ready |
| h_rx_tdata | output | 32 | Host incoming stream data |
| h_rx_tvalid | output | 1 | Host incoming stream valid |
| h_rx_tlast | output | 1 | Host incoming end of frame |
| h_rx_tready | input | 1 | Host incoming stream ready |
| st_chan_up | input | 1 | Channel-up flag |
| st_lane_up | input | 1 | Lane-up flag |
| st_hard_err | input | 1 | Hard error flag |
| st_soft_err | input | 1 | Soft error flag |
| st_frame_err | input | 1 | Frame error flag |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 5 | Mode word write data |
| reg_rdata | output | 32 | Register read data |

## Verification
Frames of one, two and several words are sent in plain numbering, echo, strip, strip-with-echo and pass-through modes. The cases are built so that local-count words, echoed words and untouched frames each give a different expected word list. Running an echo frame after a pass-through frame shows whether pass-through traffic wrongly updates the remembered number. A one-word frame under strip separates dropping the frame from forwarding it. Alternating ready patterns on both host and link outputs reveal lost or repeated words, especially around the skid register and the appended word. Loopback runs, with and without strip, and counter reads taken while the clear bit is held separate internal routing and level-held clearing from their faulty variants.

// File: rtl/seqlink_pkg.sv
package seqlink_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;
    localparam int CTL_W  = 5;
    localparam int STAT_W = 5;

    localparam int CTL_LOOP  = 0;
    localparam int CTL_CLR   = 1;
    localparam int CTL_SWSEQ = 2;
    localparam int CTL_STRIP = 3;
    localparam int CTL_ECHO  = 4;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_INLO  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_INHI  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_OUTHI = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_OUTLO = 5'h1C;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_PASS = 2'd1,
        TX_BODY = 2'd2,
        TX_SEQ  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_PASS = 2'd1,
        RX_HOLD = 2'd2
    } rx_state_e;
endpackage

// File: rtl/seqlink_frame_ctr.sv
module seqlink_frame_ctr #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/seqlink_regs.sv
module seqlink_regs
    import seqlink_pkg::*;
#(
    parameter int NUM_CTR = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [CTL_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [STAT_W-1:0]   flags,
    input  logic [NUM_CTR-1:0]  done,
    output logic [CTL_W-1:0]    mode,
    output logic [2*REG_W-1:0]  cnt [NUM_CTR]
);
    localparam int CNT_W = 2 * REG_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (reg_wr && reg_addr == OFS_MODE) begin
            mode <= reg_wdata;
        end
    end

    // index 0: incoming frames, index 1: outgoing frames
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        seqlink_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (mode[CTL_CLR]),
            .inc   (done[g]),
            .cnt   (cnt[g])
        );
    end

    always_comb begin
        case (reg_addr)
            OFS_STAT:  reg_rdata = {{(REG_W-STAT_W){1'b0}}, flags};
            OFS_MODE:  reg_rdata = {{(REG_W-CTL_W){1'b0}}, mode};
            OFS_INLO:  reg_rdata = cnt[0][REG_W-1:0];
            OFS_INHI:  reg_rdata = cnt[0][CNT_W-1:REG_W];
            OFS_OUTHI: reg_rdata = cnt[1][CNT_W-1:REG_W];
            OFS_OUTLO: reg_rdata = cnt[1][REG_W-1:0];
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/seqlink_tx.sv
module seqlink_tx
    import seqlink_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              echo,
    input  logic [DATA_W-1:0] echo_seq,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready
);
    tx_state_e         state_q, state_nx;
    logic [DATA_W-1:0] seq_cnt_q;
    logic [DATA_W-1:0] seq_word_q;
    logic              s_fire;

    assign s_fire = s_tvalid && s_tready;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (s_fire) begin
                    if (bypass) begin
                        state_nx = s_tlast ? TX_IDLE : TX_PASS;
                    end else begin
                        state_nx = s_tlast ? TX_SEQ : TX_BODY;
                    end
                end
            end
            TX_PASS: if (s_fire && s_tlast) state_nx = TX_IDLE;
            TX_BODY: if (s_fire && s_tlast) state_nx = TX_SEQ;
            TX_SEQ:  if (m_tready) state_nx = TX_IDLE;
            default: state_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        m_tdata  = s_tdata;
        m_tvalid = s_tvalid;
        m_tlast  = 1'b0;
        s_tready = m_tready;
        unique case (state_q)
            TX_IDLE: m_tlast = bypass && s_tlast;
            TX_PASS: m_tlast = s_tlast;
            TX_BODY: m_tlast = 1'b0;
            TX_SEQ: begin
                m_tdata  = seq_word_q;
                m_tvalid = 1'b1;
                m_tlast  = 1'b1;
                s_tready = 1'b0;
            end
            default: m_tlast = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TX_IDLE;
            seq_cnt_q  <= '0;
            seq_word_q <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q != TX_SEQ && state_nx == TX_SEQ) begin
                seq_word_q <= echo ? echo_seq : seq_cnt_q;
            end
            if (state_q == TX_SEQ && m_tready) begin
                seq_cnt_q <= seq_cnt_q + {{(DATA_W-1){1'b0}}, 1'b1};
            end
        end
    end
endmodule

// File: rtl/seqlink_rx.sv
module seqlink_rx
    import seqlink_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              strip,
    output logic [DATA_W-1:0] last_seq,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready
);
    rx_state_e         state_q, state_nx;
    logic [DATA_W-1:0] skid_q;
    logic              hw_q;
    logic              strip_now;
    logic              frame_hw;
    logic              s_fire;

    assign strip_now = strip && !bypass;
    assign s_fire    = s_tvalid && s_tready;
    assign frame_hw  = (state_q == RX_IDLE) ? !bypass : hw_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (s_fire && !s_tlast) begin
                    state_nx = strip_now ? RX_HOLD : RX_PASS;
                end
            end
            RX_PASS: if (s_fire && s_tlast) state_nx = RX_IDLE;
            RX_HOLD: if (s_fire && s_tlast) state_nx = RX_IDLE;
            default: state_nx = RX_IDLE;
        endcase
    end

    always_comb begin
        m_tdata  = s_tdata;
        m_tvalid = s_tvalid;
        m_tlast  = s_tlast;
        s_tready = m_tready;
        unique case (state_q)
            RX_IDLE: begin
                if (strip_now) begin
                    m_tvalid = 1'b0;
                    m_tlast  = 1'b0;
                    s_tready = 1'b1;
                end
            end
            RX_PASS: m_tdata = s_tdata;
            RX_HOLD: m_tdata = skid_q;
            default: m_tvalid = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            skid_q   <= '0;
            hw_q     <= 1'b0;
            last_seq <= '0;
        end else begin
            state_q <= state_nx;
            if (s_fire && (state_q == RX_HOLD || (state_q == RX_IDLE && strip_now))) begin
                skid_q <= s_tdata;
            end
            if (s_fire && state_q == RX_IDLE) begin
                hw_q <= !bypass;
            end
            if (s_fire && s_tlast && frame_hw) begin
                last_seq <= s_tdata;
            end
        end
    end
endmodule

// File: rtl/seqlink_wrap.sv
module seqlink_wrap
    import seqlink_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] h_tx_tdata,
    input  logic              h_tx_tvalid,
    input  logic              h_tx_tlast,
    output logic              h_tx_tready,
    output logic [DATA_W-1:0] l_tx_tdata,
    output logic              l_tx_tvalid,
    output logic              l_tx_tlast,
    input  logic              l_tx_tready,
    input  logic [DATA_W-1:0] l_rx_tdata,
    input  logic              l_rx_tvalid,
    input  logic              l_rx_tlast,
    output logic              l_rx_tready,
    output logic [DATA_W-1:0] h_rx_tdata,
    output logic              h_rx_tvalid,
    output logic              h_rx_tlast,
    input  logic              h_rx_tready,
    input  logic              st_chan_up,
    input  logic              st_lane_up,
    input  logic              st_hard_err,
    input  logic              st_soft_err,
    input  logic              st_frame_err,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CTL_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int CNT_W = 2 * REG_W;

    logic [CTL_W-1:0]  mode_q;
    logic [CNT_W-1:0]  cnt_v [2];
    logic [CNT_W-1:0]  in_cnt, out_cnt;
    logic [DATA_W-1:0] echo_seq;
    logic              loop_on;
    logic              in_done, out_done;

    logic [DATA_W-1:0] tx_tdata;
    logic              tx_tvalid, tx_tlast, tx_tready;
    logic [DATA_W-1:0] rx_tdata;
    logic              rx_tvalid, rx_tlast, rx_tready;

    assign loop_on = mode_q[CTL_LOOP];
    assign in_cnt  = cnt_v[0];
    assign out_cnt = cnt_v[1];

    seqlink_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .flags     ({st_frame_err, st_soft_err, st_hard_err, st_lane_up, st_chan_up}),
        .done      ({out_done, in_done}),
        .mode      (mode_q),
        .cnt       (cnt_v)
    );

    seqlink_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass   (mode_q[CTL_SWSEQ]),
        .echo     (mode_q[CTL_ECHO]),
        .echo_seq (echo_seq),
        .s_tdata  (h_tx_tdata),
        .s_tvalid (h_tx_tvalid),
        .s_tlast  (h_tx_tlast),
        .s_tready (h_tx_tready),
        .m_tdata  (tx_tdata),
        .m_tvalid (tx_tvalid),
        .m_tlast  (tx_tlast),
        .m_tready (tx_tready)
    );

    // loopback routing between the two paths
    assign tx_tready   = loop_on ? rx_tready : l_tx_tready;
    assign l_tx_tdata  = tx_tdata;
    assign l_tx_tlast  = tx_tlast;
    assign l_tx_tvalid = tx_tvalid && !loop_on;

    assign rx_tdata    = loop_on ? tx_tdata  : l_rx_tdata;
    assign rx_tvalid   = loop_on ? tx_tvalid : l_rx_tvalid;
    assign rx_tlast    = loop_on ? tx_tlast  : l_rx_tlast;
    assign l_rx_tready = rx_tready && !loop_on;

    assign in_done  = rx_tvalid && rx_tready && rx_tlast;
    assign out_done = tx_tvalid && tx_tready && tx_tlast;

    seqlink_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass   (mode_q[CTL_SWSEQ]),
        .strip    (mode_q[CTL_STRIP]),
        .last_seq (echo_seq),
        .s_tdata  (rx_tdata),
        .s_tvalid (rx_tvalid),
        .s_tlast  (rx_tlast),
        .s_tready (rx_tready),
        .m_tdata  (h_rx_tdata),
        .m_tvalid (h_rx_tvalid),
        .m_tlast  (h_rx_tlast),
        .m_tready (h_rx_tready)
    );
endmodule

// File: rtl/seqlink_chk.sv
module seqlink_chk
    import seqlink_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [CTL_W-1:0]  mode,
    input logic [DATA_W-1:0] l_tx_tdata,
    input logic              l_tx_tvalid,
    input logic              l_tx_tlast,
    input logic              l_tx_tready,
    input logic              l_rx_tready,
    input logic [DATA_W-1:0] h_rx_tdata,
    input logic              h_rx_tvalid,
    input logic              h_rx_tlast,
    input logic              h_rx_tready,
    input logic              in_done,
    input logic              out_done,
    input logic [2*REG_W-1:0] in_cnt,
    input logic [2*REG_W-1:0] out_cnt
);
    a_r12_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (l_tx_tvalid && !l_tx_tready && !reg_wr)
        |=> (l_tx_tvalid && $stable(l_tx_tdata) && $stable(l_tx_tlast)));

    a_r12_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rx_tvalid && !h_rx_tready && !reg_wr)
        |=> (h_rx_tvalid && $stable(h_rx_tdata) && $stable(h_rx_tlast)));

    a_r10_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
        mode[CTL_CLR] |=> (in_cnt == '0 && out_cnt == '0));

    a_r9_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done && !mode[CTL_CLR]) |=> (in_cnt == $past(in_cnt) + 64'd1));

    a_r9_out_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !mode[CTL_CLR]) |=> (out_cnt == $past(out_cnt) + 64'd1));

    a_r11_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mode[CTL_LOOP] |-> (!l_tx_tvalid && !l_rx_tready));
endmodule

bind seqlink_wrap seqlink_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .mode        (mode_q),
    .l_tx_tdata  (l_tx_tdata),
    .l_tx_tvalid (l_tx_tvalid),
    .l_tx_tlast  (l_tx_tlast),
    .l_tx_tready (l_tx_tready),
    .l_rx_tready (l_rx_tready),
    .h_rx_tdata  (h_rx_tdata),
    .h_rx_tvalid (h_rx_tvalid),
    .h_rx_tlast  (h_rx_tlast),
    .h_rx_tready (h_rx_tready),
    .in_done     (in_done),
    .out_done    (out_done),
    .in_cnt      (in_cnt),
    .out_cnt     (out_cnt)
);

// File: tb/seqlink_wrap_test.sv
`timescale 1ns/1ps
module seqlink_wrap_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] h_tx_tdata;  logic h_tx_tvalid, h_tx_tlast, h_tx_tready;
    logic [31:0] l_tx_tdata;  logic l_tx_tvalid, l_tx_tlast, l_tx_tready;
    logic [31:0] l_rx_tdata;  logic l_rx_tvalid, l_rx_tlast, l_rx_tready;
    logic [31:0] h_rx_tdata;  logic h_rx_tvalid, h_rx_tlast, h_rx_tready;
    logic [4:0]  flags;
    logic [4:0]  reg_addr;
    logic        reg_wr;
    logic [4:0]  reg_wdata;
    logic [31:0] reg_rdata;

    always #10 clk = ~clk;

    seqlink_wrap uut (
        .clk(clk), .rst_n(rst_n),
        .h_tx_tdata(h_tx_tdata), .h_tx_tvalid(h_tx_tvalid), .h_tx_tlast(h_tx_tlast), .h_tx_tready(h_tx_tready),
        .l_tx_tdata(l_tx_tdata), .l_tx_tvalid(l_tx_tvalid), .l_tx_tlast(l_tx_tlast), .l_tx_tready(l_tx_tready),
        .l_rx_tdata(l_rx_tdata), .l_rx_tvalid(l_rx_tvalid), .l_rx_tlast(l_rx_tlast), .l_rx_tready(l_rx_tready),
        .h_rx_tdata(h_rx_tdata), .h_rx_tvalid(h_rx_tvalid), .h_rx_tlast(h_rx_tlast), .h_rx_tready(h_rx_tready),
        .st_chan_up(flags[0]), .st_lane_up(flags[1]), .st_hard_err(flags[2]),
        .st_soft_err(flags[3]), .st_frame_err(flags[4]),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // backpressure generator
    int   bp_cnt = 0;
    logic bp_en  = 1'b0;
    always @(posedge clk) bp_cnt <= bp_cnt + 1;
    assign l_tx_tready = !bp_en || (bp_cnt % 3 != 0);
    assign h_rx_tready = !bp_en || (bp_cnt % 4 != 1);

    // output monitors, sampled away from the active edge
    logic [32:0] ltx_b [64];
    logic [32:0] hrx_b [64];
    int ltx_n = 0;
    int hrx_n = 0;
    always @(negedge clk) begin
        if (l_tx_tvalid && l_tx_tready) begin
            if (ltx_n < 64) ltx_b[ltx_n] = {l_tx_tlast, l_tx_tdata};
            ltx_n = ltx_n + 1;
        end
        if (h_rx_tvalid && h_rx_tready) begin
            if (hrx_n < 64) hrx_b[hrx_n] = {h_rx_tlast, h_rx_tdata};
            hrx_n = hrx_n + 1;
        end
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    logic [32:0] exp_w [32];
    int exp_n;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic cmp_buf(string tag, bit host);
        int n;
        n = host ? hrx_n : ltx_n;
        chk({tag, " word count"}, 64'(n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < n && i < 64; i++) begin
            chk(tag, 64'(host ? hrx_b[i] : ltx_b[i]), 64'(exp_w[i]));
        end
    endtask

    task automatic reg_write(logic [4:0] a, logic [4:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #2;
    endtask

    task automatic send_tx(int len, logic [31:0] base);
        for (int i = 0; i < len; i++) begin
            h_tx_tdata = base + i; h_tx_tvalid = 1'b1; h_tx_tlast = (i == len - 1);
            do @(negedge clk); while (!h_tx_tready);
            @(posedge clk); #2;
        end
        h_tx_tvalid = 1'b0; h_tx_tlast = 1'b0;
    endtask

    task automatic send_rx(int len, logic [31:0] base, logic [31:0] seqw);
        for (int i = 0; i < len; i++) begin
            l_rx_tdata = (i == len - 1) ? seqw : base + i;
            l_rx_tvalid = 1'b1; l_rx_tlast = (i == len - 1);
            do @(negedge clk); while (!l_rx_tready);
            @(posedge clk); #2;
        end
        l_rx_tvalid = 1'b0; l_rx_tlast = 1'b0;
    endtask

    task automatic drain();
        repeat (12) @(posedge clk);
        #2;
    endtask

    // rows: {mode[4:0], tx_len[3:0], rx_len[3:0], backpressure}
    localparam int NROW = 10;
    localparam logic [13:0] TBL [NROW] = '{
        {5'b00000, 4'd3, 4'd3, 1'b0},
        {5'b00000, 4'd1, 4'd2, 1'b1},
        {5'b01000, 4'd2, 4'd4, 1'b1},
        {5'b01000, 4'd1, 4'd1, 1'b0},
        {5'b10000, 4'd2, 4'd3, 1'b0},
        {5'b11100, 4'd3, 4'd3, 1'b1},
        {5'b10000, 4'd1, 4'd2, 1'b0},
        {5'b00000, 4'd4, 4'd5, 1'b1},
        {5'b01000, 4'd3, 4'd2, 1'b1},
        {5'b11000, 4'd2, 4'd3, 1'b1}
    };

    logic [31:0] m_local;
    logic [31:0] m_last_rx;
    logic [31:0] rd;

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        h_tx_tdata = '0; h_tx_tvalid = 1'b0; h_tx_tlast = 1'b0;
        l_rx_tdata = '0; l_rx_tvalid = 1'b0; l_rx_tlast = 1'b0;
        flags = 5'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        m_local = '0; m_last_rx = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        // reset state
        reg_read(5'h04, rd); chk("R2 mode after reset", 64'(rd), 64'd0);
        reg_read(5'h08, rd); chk("R9 in lo after reset", 64'(rd), 64'd0);
        reg_read(5'h1C, rd); chk("R9 out lo after reset", 64'(rd), 64'd0);
        chk("R12 outputs idle after reset", {62'd0, l_tx_tvalid, h_rx_tvalid}, 64'd0);

        // status flags
        flags = 5'b10101;
        reg_read(5'h00, rd); chk("R1 status pattern a", 64'(rd), 64'h15);
        flags = 5'b01010;
        reg_write(5'h00, 5'h1F);
        reg_read(5'h00, rd); chk("R1 status pattern b after write", 64'(rd), 64'h0A);
        reg_write(5'h04, 5'h1C);
        reg_read(5'h04, rd); chk("R2 mode readback", 64'(rd), 64'h1C);

        // table walk
        for (int r = 0; r < NROW; r++) begin
            logic [4:0]  c;
            int          tl, rl;
            logic        byp, stp;
            logic [31:0] tb, rb, sq;
            string       tg;
            c   = TBL[r][13:9];
            tl  = int'(TBL[r][8:5]);
            rl  = int'(TBL[r][4:1]);
            bp_en = TBL[r][0];
            byp = c[2];
            stp = c[3] && !c[2];
            tb  = 32'hA000_0000 + (r << 8);
            rb  = 32'hB000_0000 + (r << 8);
            sq  = 32'h5EC0_0000 + r;
            reg_write(5'h04, c);

            exp_n = 0;
            for (int i = 0; i < tl; i++) begin
                exp_w[exp_n] = {byp ? (i == tl - 1) : 1'b0, tb + i};
                exp_n++;
            end
            if (!byp) begin
                exp_w[exp_n] = {1'b1, c[4] ? m_last_rx : m_local};
                exp_n++;
                m_local = m_local + 1;
            end
            tg = byp ? "R3 tx bypass" : (c[4] ? "R6 tx echo" : "R4 R5 tx local seq");
            if (bp_en) tg = {tg, " R12"};
            ltx_n = 0;
            send_tx(tl, tb);
            drain();
            cmp_buf(tg, 1'b0);

            exp_n = 0;
            if (stp) begin
                for (int i = 0; i < rl - 1; i++) begin
                    exp_w[exp_n] = {(i == rl - 2), rb + i};
                    exp_n++;
                end
            end else begin
                for (int i = 0; i < rl; i++) begin
                    exp_w[exp_n] = {(i == rl - 1), (i == rl - 1) ? sq : rb + i};
                    exp_n++;
                end
            end
            tg = byp ? "R3 rx bypass" : (stp ? (rl == 1 ? "R8 rx drop" : "R7 rx strip") : "R7 rx keep");
            if (bp_en) tg = {tg, " R12"};
            hrx_n = 0;
            send_rx(rl, rb, sq);
            drain();
            cmp_buf(tg, 1'b1);
            if (!byp) m_last_rx = sq;
        end
        bp_en = 1'b0;

        reg_read(5'h08, rd); chk("R9 R8 in lo after table", 64'(rd), 64'd10);
        reg_read(5'h0C, rd); chk("R9 in hi after table", 64'(rd), 64'd0);
        reg_read(5'h1C, rd); chk("R9 out lo after table", 64'(rd), 64'd10);
        reg_read(5'h18, rd); chk("R9 out hi after table", 64'(rd), 64'd0);

        // counter clear held as a level
        reg_write(5'h04, 5'b00010);
        ltx_n = 0; hrx_n = 0;
        send_tx(1, 32'hC000_0000); m_local = m_local + 1;
        send_rx(1, 32'hC100_0000, 32'hC1C1_C1C1); m_last_rx = 32'hC1C1_C1C1;
        drain();
        reg_read(5'h08, rd); chk("R10 in held at zero", 64'(rd), 64'd0);
        reg_read(5'h1C, rd); chk("R10 out held at zero", 64'(rd), 64'd0);
        reg_write(5'h04, 5'b00000);
        send_tx(2, 32'hC200_0000); m_local = m_local + 1;
        drain();
        reg_read(5'h1C, rd); chk("R10 out resumes", 64'(rd), 64'd1);
        reg_read(5'h08, rd); chk("R10 in stays zero", 64'(rd), 64'd0);

        // loopback, no strip
        reg_write(5'h04, 5'b00001);
        l_rx_tdata = 32'hDEAD_BEEF; l_rx_tvalid = 1'b1; l_rx_tlast = 1'b1;
        ltx_n = 0; hrx_n = 0;
        exp_n = 3;
        exp_w[0] = {1'b0, 32'hD000_0000};
        exp_w[1] = {1'b0, 32'hD000_0001};
        exp_w[2] = {1'b1, m_local};
        m_local = m_local + 1;
        send_tx(2, 32'hD000_0000);
        @(negedge clk);
        chk("R11 external rx not ready", 64'(l_rx_tready), 64'd0);
        @(posedge clk); #2;
        drain();
        cmp_buf("R11 loopback keep", 1'b1);
        chk("R11 nothing on external tx", 64'(ltx_n), 64'd0);

        // loopback with strip and backpressure
        reg_write(5'h04, 5'b01001);
        bp_en = 1'b1;
        hrx_n = 0;
        exp_n = 3;
        for (int i = 0; i < 3; i++) exp_w[i] = {(i == 2), 32'hE000_0000 + i};
        send_tx(3, 32'hE000_0000);
        drain();
        cmp_buf("R11 R7 R12 loopback strip", 1'b1);
        bp_en = 1'b0;
        l_rx_tvalid = 1'b0; l_rx_tlast = 1'b0;
        reg_write(5'h04, 5'b00000);
        reg_read(5'h08, rd); chk("R11 R9 in counts looped frames", 64'(rd), 64'd2);
        reg_read(5'h1C, rd); chk("R11 R9 out counts looped frames", 64'(rd), 64'd3);

        finish_run();
    end
endmodule